// File: doc/BRIEF.md
# Lane-Addressable GPIO Direction Register Bank

This block keeps the direction setting of every pin on a set of 32-bit general purpose I/O ports and turns it into output-enable vectors for the pad ring. A direction bit of 1 turns its pin into an output, and a bit of 0 leaves it as an input. After reset every pin is an input.

Software reaches each port's direction bits in three ways. A whole-word register changes all 32 bits at once. A half-word alias changes one 16-bit half. A byte alias changes one 8-bit lane. The two aliases sit on the same storage as the word register, so a driver can retarget one lane of a port without a read-modify-write of the rest. The bus is word addressed and qualified by byte enables. The byte enables carry the access size, and each register accepts only its own size.

Two pins on port 0 have to move together. Their pad enables are only asserted when both stored bits are 1, so a mismatched pair falls back to input. The stored bits themselves always read back exactly as written.

Top module: `gpio_dir_lanes`

## Requirements
- R1: After reset, every stored direction bit is 0, every bit of `pad_oe` is 0 and `bus_rdata` is 0.
- R2: The address is `{port, kind}`, where kind is the low 2 bits of `bus_addr`. Kind 0 is the word register. A write with `bus_be` = 4'b1111 replaces all 32 direction bits of that port, and a read with that pattern returns them.
- R3: A kind 0 access with any `bus_be` other than 4'b1111 is ignored on write and reads as 0.
- R4: Kind 1 is the half-word alias. With `bus_be` = 4'b0011 it writes bits 15:0, and with 4'b1100 it writes bits 31:16. Bits outside that half keep their value. A read returns the selected half in place with all other bits 0. Any other `bus_be` pattern is ignored on write and reads as 0.
- R5: Kind 2 is the byte alias. It needs exactly one `bus_be` bit set; bit k selects bits 8k+7:8k. It writes only that byte and reads it in place with all other bits 0. Any other pattern is ignored on write and reads as 0.
- R6: A write changes only the addressed port. An address whose port field is NUM_PORTS or higher, or whose kind is 3, is ignored on write and reads as 0.
- R7: For every pin except the coupled pair, `pad_oe[32*p+n]` equals bit n of port p's stored direction. A value of 1 means the pin drives.
- R8: On port 0, `pad_oe` bits 29 and 30 are both 1 only when stored bits 29 and 30 are both 1. Otherwise both are 0. The stored bits still read back as written.
- R9: `bus_rdata` carries the read result in the cycle after the clock edge that samples `bus_rd`, and it is 0 in any cycle that follows an edge without a read. A read and a write issued in the same cycle return the contents from before the write.
- R10: A write becomes visible on `pad_oe` right after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Word address: port index in the upper bits, register kind in bits 1:0 |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_be | input | 4 | Byte enables; the pattern encodes the access size |
| bus_wdata | input | 32 | Write data, lane aligned |
| bus_rdata | output | 32 | Registered read data |
| pad_oe | output | 160 | Output enables, 32 per port, port 0 in the low bits |

## Verification
A read and a write can land in the same cycle, either on the same register or on overlapping aliases of one port. The read then has to return the old contents, while `pad_oe` already shows the new contents one edge later. The bench provokes this with directed same-address write-and-read cycles and with random cycles that raise both strobes. It judges the result against a bench model that takes the read value before it applies the write. The coupled pin pair is driven through every combination of its two bits, using both word writes and byte writes, and the model predicts both the pad enables and the readback.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;

    localparam int PIN_W  = 32;
    localparam int LANE_W = 8;
    localparam int BE_W   = PIN_W / LANE_W;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_WORD = 2'd0,
        KIND_HALF = 2'd1,
        KIND_BYTE = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic             legal;
        logic [7:0]       port;
        reg_kind_e        kind;
        logic [PIN_W-1:0] mask;
    } access_t;

    function automatic logic [PIN_W-1:0] expand_be(input logic [BE_W-1:0] be);
        logic [PIN_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
        end
        return m;
    endfunction

    function automatic logic size_fits(input reg_kind_e kind, input logic [BE_W-1:0] be);
        logic ok;
        case (kind)
            KIND_WORD: ok = (be == {BE_W{1'b1}});
            KIND_HALF: ok = (be == 4'b0011) || (be == 4'b1100);
            KIND_BYTE: ok = (be == 4'b0001) || (be == 4'b0010) ||
                            (be == 4'b0100) || (be == 4'b1000);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/gpio_dir_decode.sv
module gpio_dir_decode
    import gpio_dir_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = PIDX_W + KIND_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output access_t           acc
);

    logic [PIDX_W-1:0] port_f;
    reg_kind_e         kind_f;
    logic              port_ok;

    assign port_f  = addr[ADDR_W-1:KIND_W];
    assign kind_f  = reg_kind_e'(addr[KIND_W-1:0]);
    assign port_ok = (32'(port_f) < NUM_PORTS);

    always_comb begin
        acc       = '0;
        acc.port  = 8'(port_f);
        acc.kind  = kind_f;
        acc.legal = port_ok && (kind_f != KIND_NONE) && size_fits(kind_f, be);
        acc.mask  = acc.legal ? expand_be(be) : '0;
    end

endmodule

// File: rtl/gpio_dir_bank.sv
module gpio_dir_bank
    import gpio_dir_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    localparam int FLAT_W   = NUM_PORTS * PIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  access_t          acc,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] rdata,
    output logic [FLAT_W-1:0] dir_flat
);

    logic [PIN_W-1:0] dir_q [NUM_PORTS];
    logic [PIN_W-1:0] sel_word;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = wr && acc.legal && (acc.port == 8'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                dir_q[p] <= '0;
            end else if (hit) begin
                dir_q[p] <= (dir_q[p] & ~acc.mask) | (wdata & acc.mask);
            end
        end

        assign dir_flat[p*PIN_W +: PIN_W] = dir_q[p];

        // R4 R5: lanes outside the written mask keep their old bits
        p_lane_keep_r4: assert property (@(posedge clk) disable iff (rst)
            hit |=> ((dir_q[p] & ~$past(acc.mask)) == ($past(dir_q[p]) & ~$past(acc.mask))));
    end

    always_comb begin
        sel_word = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (acc.port == 8'(p)) sel_word = dir_q[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd && acc.legal) begin
            rdata <= sel_word & acc.mask;
        end else begin
            rdata <= '0;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_flat == '0));

    p_bad_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && !acc.legal) |=> $stable(dir_flat));

endmodule

// File: rtl/gpio_dir_padmap.sv
module gpio_dir_padmap
    import gpio_dir_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int LINK_PORT = 0,
    parameter int LINK_A    = 29,
    parameter int LINK_B    = 30,
    localparam int FLAT_W   = NUM_PORTS * PIN_W,
    localparam int BIT_A    = LINK_PORT * PIN_W + LINK_A,
    localparam int BIT_B    = LINK_PORT * PIN_W + LINK_B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAT_W-1:0] dir_flat,
    output logic [FLAT_W-1:0] oe
);

    if (LINK_PORT < NUM_PORTS) begin : g_link
        logic both_out;
        assign both_out = dir_flat[BIT_A] & dir_flat[BIT_B];

        always_comb begin
            oe        = dir_flat;
            oe[BIT_A] = both_out;
            oe[BIT_B] = both_out;
        end

        p_link_same_r8: assert property (@(posedge clk) disable iff (rst)
            oe[BIT_A] == oe[BIT_B]);

        p_link_needs_both_r8: assert property (@(posedge clk) disable iff (rst)
            oe[BIT_A] |-> (dir_flat[BIT_A] && dir_flat[BIT_B]));
    end else begin : g_plain
        assign oe = dir_flat;
    end

endmodule

// File: rtl/gpio_dir_lanes.sv
module gpio_dir_lanes
    import gpio_dir_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int LINK_PORT = 0,
    parameter int LINK_A    = 29,
    parameter int LINK_B    = 30,
    localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = PIDX_W + KIND_W,
    localparam int FLAT_W   = NUM_PORTS * PIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    output logic [FLAT_W-1:0] pad_oe
);

    access_t           acc;
    logic [FLAT_W-1:0] dir_flat;

    gpio_dir_decode #(.NUM_PORTS(NUM_PORTS)) u_decode (
        .addr (bus_addr),
        .be   (bus_be),
        .acc  (acc)
    );

    gpio_dir_bank #(.NUM_PORTS(NUM_PORTS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .acc      (acc),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .dir_flat (dir_flat)
    );

    gpio_dir_padmap #(
        .NUM_PORTS (NUM_PORTS),
        .LINK_PORT (LINK_PORT),
        .LINK_A    (LINK_A),
        .LINK_B    (LINK_B)
    ) u_padmap (
        .clk      (clk),
        .rst      (rst),
        .dir_flat (dir_flat),
        .oe       (pad_oe)
    );

    // R9: no read strobe means zero data on the next cycle
    p_idle_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

    // R3 R5 R6: reads of a wrong size or an unmapped address return zero
    p_bad_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !acc.legal) |=> (bus_rdata == '0));

    // R10: a pad enable can only rise after a write edge
    p_oe_rise_needs_write_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(pad_oe) != pad_oe) |-> $past(bus_wr));

endmodule

// File: tb/gpio_dir_lanes_tb.sv
module gpio_dir_lanes_tb_top;

    localparam int NP = 5;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP*32-1:0] pad_oe;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [31:0] model [NP];

    always #5 clk = ~clk;

    gpio_dir_lanes dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_oe    (pad_oe)
    );

    function automatic logic [31:0] model_mask(input logic [AW-1:0] a, input logic [3:0] be);
        int port = int'(a[AW-1:2]);
        int kind = int'(a[1:0]);
        logic ok;
        logic [31:0] m;
        if (port >= NP) return '0;
        case (kind)
            0: ok = (be == 4'b1111);
            1: ok = (be == 4'b0011) || (be == 4'b1100);
            2: ok = (be == 4'b0001) || (be == 4'b0010) || (be == 4'b0100) || (be == 4'b1000);
            default: ok = 1'b0;
        endcase
        if (!ok) return '0;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [NP*32-1:0] model_oe();
        logic [NP*32-1:0] v;
        for (int p = 0; p < NP; p++) v[p*32 +: 32] = model[p];
        v[29] = model[0][29] & model[0][30];
        v[30] = v[29];
        return v;
    endfunction

    function automatic string tag_for(input logic [AW-1:0] a, input logic [3:0] be);
        if (model_mask(a, be) == '0) begin
            if (a[1:0] == 2'd0 && int'(a[AW-1:2]) < NP) return "R3";
            return "R6";
        end
        case (a[1:0])
            2'd0: return "R2";
            2'd1: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_oe(input string req);
        logic [NP*32-1:0] e = model_oe();
        checks++;
        if (pad_oe !== e) begin
            errors++;
            $display("FAIL %s: pad_oe actual=%h expected=%h", req, pad_oe, e);
        end
    endtask

    // One bus cycle: drive at a falling edge, sample at the next falling edge
    task automatic bus_cycle(input logic wr, input logic rd, input logic [AW-1:0] a,
                             input logic [3:0] be, input logic [31:0] wd, input string req);
        logic [31:0] m = model_mask(a, be);
        logic [31:0] exp_rd;
        int port = int'(a[AW-1:2]);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_be = be; bus_wdata = wd;
        exp_rd = (rd && m != '0) ? (model[port] & m) : '0;   // R9: pre-write value
        if (wr && m != '0) model[port] = (model[port] & ~m) | (wd & m);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check32({req, "/R9 rdata"}, bus_rdata, exp_rd);
        check_oe({req, "/R10 pad_oe"});
    endtask

    task automatic read_back(input logic [AW-1:0] a, input logic [3:0] be, input string req);
        bus_cycle(1'b0, 1'b1, a, be, 32'h0, req);
    endtask

    function automatic logic [AW-1:0] mk(input int port, input int kind);
        return AW'((port << 2) | kind);
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < NP; p++) model[p] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check32("R1 rdata", bus_rdata, 32'h0);
        check_oe("R1 pad_oe");
        for (int p = 0; p < NP; p++) read_back(mk(p, 0), 4'hF, "R1");

        // R2: full word writes
        bus_cycle(1, 0, mk(1, 0), 4'hF, 32'hDEAD_BEEF, "R2");
        read_back(mk(1, 0), 4'hF, "R2");
        read_back(mk(2, 0), 4'hF, "R6");
        // R3: wrong sizes on the word register
        bus_cycle(1, 0, mk(1, 0), 4'b0111, 32'h0, "R3");
        read_back(mk(1, 0), 4'b0011, "R3");
        read_back(mk(1, 0), 4'hF, "R3");
        // R4: half-word aliases
        bus_cycle(1, 0, mk(2, 1), 4'b0011, 32'hFFFF_1234, "R4");
        bus_cycle(1, 0, mk(2, 1), 4'b1100, 32'hABCD_FFFF, "R4");
        bus_cycle(1, 0, mk(2, 1), 4'b0110, 32'h5555_5555, "R4");
        read_back(mk(2, 1), 4'b1100, "R4");
        read_back(mk(2, 0), 4'hF, "R4");
        // R5: byte aliases
        bus_cycle(1, 0, mk(3, 2), 4'b0100, 32'h0077_0000, "R5");
        bus_cycle(1, 0, mk(3, 2), 4'b0011, 32'hFFFF_FFFF, "R5");
        read_back(mk(3, 2), 4'b0100, "R5");
        read_back(mk(3, 0), 4'hF, "R5");
        // R6: unmapped port and kind 3
        bus_cycle(1, 0, mk(5, 0), 4'hF, 32'hFFFF_FFFF, "R6");
        bus_cycle(1, 0, mk(4, 3), 4'hF, 32'hFFFF_FFFF, "R6");
        read_back(mk(4, 3), 4'hF, "R6");
        read_back(mk(4, 0), 4'hF, "R6");
        // R7 R8: coupled pins on port 0
        bus_cycle(1, 0, mk(0, 0), 4'hF, 32'h2000_0001, "R8");
        read_back(mk(0, 0), 4'hF, "R8");
        bus_cycle(1, 0, mk(0, 2), 4'b1000, 32'h4000_0000, "R8");
        bus_cycle(1, 0, mk(0, 0), 4'hF, 32'h6000_0000, "R8");
        bus_cycle(1, 0, mk(0, 2), 4'b1000, 32'h2000_0000, "R8");
        bus_cycle(1, 0, mk(0, 0), 4'hF, 32'h9FFF_FFFF, "R7");
        // R9: write and read in one cycle return the old value
        bus_cycle(1, 1, mk(1, 0), 4'hF, 32'h0F0F_0F0F, "R9");
        bus_cycle(1, 1, mk(1, 2), 4'b0001, 32'h0000_00AA, "R9");
        read_back(mk(1, 0), 4'hF, "R9");

        // Constrained random mix
        for (int i = 0; i < 1500; i++) begin
            logic [3:0] be_pick [8] = '{4'hF, 4'h3, 4'hC, 4'h1, 4'h2, 4'h4, 4'h8, 4'h0};
            logic [AW-1:0] a;
            logic [3:0] be;
            int r = int'($urandom_range(0, 9));
            a  = AW'($urandom_range(0, 31));
            be = (r < 8) ? be_pick[r] : 4'($urandom);
            bus_cycle(1'($urandom), 1'($urandom), a, be, $urandom, tag_for(a, be));
        end
        for (int p = 0; p < NP; p++) read_back(mk(p, 0), 4'hF, "R7");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule